// File: doc/BRIEF.md
# T1 Framing-Bit Position Searcher

This block finds the framing bit in a serial DS1 receive stream. It runs beside the receive path and does not stall it. Every bit offset inside one framing span is treated as a possible framing position. A span is two frames (386 bits) in D4 mode and four frames (772 bits) in ESF mode, so each candidate sees exactly one bit per span. For each candidate the block keeps the last three bits it received, plus a survivor flag, in a single-port-style RAM indexed by the running bit offset.

Once a candidate holds three bits, its next bit has to equal the value that its 3-bit history predicts for the selected framing pattern. A candidate that misses the prediction is dropped. The block makes a decision at the end of the tenth span and at the end of every span after it. One survivor gives an immediate alignment. No survivors restart the search. If more than one candidate is still alive after the 24th span, the block takes the first survivor that appears in the following span.

A software reframe request moves the scan start to one position past the current alignment, so the search does not settle straight back onto the same mimic. While a search runs, a freeze output holds signalling and suspends framing-error counting in the surrounding logic. A one-cycle lock pulse is provided so that an outside CRC-6 checker can confirm a new alignment or veto it with a reframe request.

Top module: `t1fa_aligner`

## Requirements
- R1: While reset is high and on the first cycle after it, `in_frame` is 0, `freeze` is 1, `align_pos` is 0, and `fbit_strobe` and `lock_strobe` are 0.
- R2: The span is 386 bits when `esf_mode`=0 and 772 bits when `esf_mode`=1. `esf_mode` changes only while reset is high. Strobes on `bit_en` are separated by at least one idle cycle. Every offset in the span is a candidate, and a candidate receives one bit per span.
- R3: In D4 mode the only valid histories (oldest bit first) are 010 and 101. The next bit must be the complement of the newest bit. Any other history, or a wrong bit, drops the candidate.
- R4: In ESF mode the candidate must follow the repeating sequence 0,0,1,0,1,1. The valid histories with their predicted next bit are 001→0, 010→1, 011→0, 100→1, 101→1, 110→0. The histories 000 and 111 drop the candidate.
- R5: A search window opens at the first strobe whose offset equals the start position, and no candidate is checked before it holds three bits. If exactly one candidate survives the 10th span of a window, `in_frame` rises on the strobe that closes that span and `align_pos` takes that offset. The block never aligns before that strobe.
- R6: If no candidate survives at the close of the 10th span, or at the close of any later span, the search restarts. A new window opens at the next strobe that reaches the start position.
- R7: If two or more candidates survive the 24th span, the block aligns during the 25th span to the first surviving candidate in scan order counted from the start position. The alignment happens on that candidate's strobe.
- R8: A reframe request clears `in_frame` on the next clock edge. If the block was aligned, the next search starts one offset past the old `align_pos`, wrapping to 0 after the last offset. Otherwise the start position is kept. After reset the start position is 0.
- R9: `freeze` is the inverse of `in_frame` at all times, so it stays high for the whole of every search.
- R10: While aligned, `fbit_strobe` pulses for one cycle on each strobe at the `align_pos` offset, which is once per span. `lock_strobe` pulses for one cycle, only on the cycle `in_frame` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Strobe marking a valid receive bit |
| rx_bit | input | 1 | Serial receive data, sampled with `bit_en` |
| esf_mode | input | 1 | 0 selects D4 pattern, 1 selects ESF pattern |
| reframe_req | input | 1 | Request to drop alignment and search again |
| in_frame | output | 1 | Alignment held |
| align_pos | output | POS_W (10) | Offset in the span of the aligned framing bit |
| freeze | output | 1 | Hold signalling and suspend framing error counts |
| fbit_strobe | output | 1 | Pulse on the aligned framing bit |
| lock_strobe | output | 1 | Pulse when a new alignment is taken |

## Verification
The in-line assertions check the relations that hold on every cycle. The framing-bit pulse appears only while aligned. The lock pulse marks only a rising `in_frame`. A reframe request always drops alignment on the next edge. `align_pos` holds steady while aligned, `freeze` covers every searching cycle, the bit offset stays inside the span and the span counter stays bounded. What the assertions cannot show is which offset the block chooses and on which strobe it does so. The bench scenarios cover those points: the exact 10th-span lock, the drop of D4 and ESF mimics under the opposite pattern, a restart after an empty window, the 25th-span tie-break, and a reframe start position that steps past two mimics in turn.

// File: rtl/t1fa_pkg.sv
package t1fa_pkg;

  localparam int HIST_W = 3;

  typedef enum logic [1:0] {
    S_ARM  = 2'd0,
    S_SCAN = 2'd1,
    S_LATE = 2'd2,
    S_LOCK = 2'd3
  } srch_state_e;

  typedef struct packed {
    logic              alive;
    logic [HIST_W-1:0] hist;
  } cand_t;

  // history bit [2] is the oldest sample, bit [0] the newest
  function automatic logic hist_valid(input logic esf, input logic [HIST_W-1:0] h);
    if (esf) return !((h == 3'b000) || (h == 3'b111));
    return (h == 3'b010) || (h == 3'b101);
  endfunction

  function automatic logic hist_predict(input logic esf, input logic [HIST_W-1:0] h);
    if (esf) begin
      case (h)
        3'b010, 3'b100, 3'b101: return 1'b1;
        default:                return 1'b0;
      endcase
    end
    return ~h[0];
  endfunction

endpackage

// File: rtl/t1fa_pos_ctr.sv
module t1fa_pos_ctr #(
  parameter int FRAME_BITS = 193,
  parameter int D4_FRAMES  = 2,
  parameter int ESF_FRAMES = 4,
  parameter int POS_W      = $clog2(FRAME_BITS * ESF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             esf_mode,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] last_pos
);

  localparam int D4_LEN  = FRAME_BITS * D4_FRAMES;
  localparam int ESF_LEN = FRAME_BITS * ESF_FRAMES;

  assign last_pos = esf_mode ? POS_W'(ESF_LEN - 1) : POS_W'(D4_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (bit_en) begin
      if (pos >= last_pos) pos <= '0;
      else                 pos <= pos + 1'b1;
    end
  end

  p_pos_in_span_r2: assert property (@(posedge clk) disable iff (rst)
    pos <= last_pos);

  // candidate RAM read is prefetched one cycle ahead of each strobe
  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> !bit_en);

endmodule

// File: rtl/t1fa_cand_ram.sv
module t1fa_cand_ram #(
  parameter int DEPTH = 772,
  parameter int WIDTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/t1fa_cand_eval.sv
module t1fa_cand_eval
  import t1fa_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int CHECK_FROM = HIST_W
) (
  input  logic             esf_mode,
  input  logic [CNT_W-1:0] span_cnt,
  input  cand_t            rd_ent,
  input  logic             rx_bit,
  output cand_t            wr_ent,
  output logic             alive
);

  logic first_span;
  logic checking;
  logic hit;

  assign first_span = (span_cnt == '0);
  assign checking   = (span_cnt >= CNT_W'(CHECK_FROM));
  assign hit        = hist_valid(esf_mode, rd_ent.hist) &&
                      (rx_bit == hist_predict(esf_mode, rd_ent.hist));

  always_comb begin
    if (first_span) begin
      alive       = 1'b1;
      wr_ent.hist = {{(HIST_W-1){1'b0}}, rx_bit};
    end else begin
      alive       = checking ? (rd_ent.alive && hit) : rd_ent.alive;
      wr_ent.hist = {rd_ent.hist[HIST_W-2:0], rx_bit};
    end
    wr_ent.alive = alive;
  end

endmodule

// File: rtl/t1fa_aligner.sv
module t1fa_aligner
  import t1fa_pkg::*;
#(
  parameter int FRAME_BITS    = 193,
  parameter int D4_FRAMES     = 2,
  parameter int ESF_FRAMES    = 4,
  parameter int DECIDE_SPANS  = 10,
  parameter int TIMEOUT_SPANS = 24,
  parameter int POS_W         = $clog2(FRAME_BITS * ESF_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             esf_mode,
  input  logic             reframe_req,
  output logic             in_frame,
  output logic [POS_W-1:0] align_pos,
  output logic             freeze,
  output logic             fbit_strobe,
  output logic             lock_strobe
);

  localparam int MAX_SPAN = FRAME_BITS * ESF_FRAMES;
  localparam int CNT_W    = $clog2(TIMEOUT_SPANS + 1);
  localparam int ENT_W    = $bits(cand_t);
  localparam logic [CNT_W-1:0] DECIDE_AT = CNT_W'(DECIDE_SPANS - 1);
  localparam logic [CNT_W-1:0] LATE_AT   = CNT_W'(TIMEOUT_SPANS - 1);
  localparam logic [CNT_W-1:0] LATE_SPAN = CNT_W'(TIMEOUT_SPANS);

  srch_state_e      state;
  logic [POS_W-1:0] pos, last_pos, start_pos, end_pos, surv_pos, pick_pos, next_start;
  logic [CNT_W-1:0] span_cnt;
  logic [1:0]       surv_cnt, surv_next;
  logic             opens, active, at_end, cand_alive;
  logic [ENT_W-1:0] rd_raw;
  cand_t            rd_ent, wr_ent;

  t1fa_pos_ctr #(
    .FRAME_BITS(FRAME_BITS), .D4_FRAMES(D4_FRAMES),
    .ESF_FRAMES(ESF_FRAMES), .POS_W(POS_W)
  ) u_pos (
    .clk(clk), .rst(rst), .bit_en(bit_en), .esf_mode(esf_mode),
    .pos(pos), .last_pos(last_pos)
  );

  t1fa_cand_ram #(.DEPTH(MAX_SPAN), .WIDTH(ENT_W), .AW(POS_W)) u_ram (
    .clk(clk), .we(active), .waddr(pos), .wdata(wr_ent),
    .raddr(pos), .rdata(rd_raw)
  );

  assign rd_ent = cand_t'(rd_raw);

  t1fa_cand_eval #(.CNT_W(CNT_W), .CHECK_FROM(HIST_W)) u_eval (
    .esf_mode(esf_mode), .span_cnt(span_cnt), .rd_ent(rd_ent),
    .rx_bit(rx_bit), .wr_ent(wr_ent), .alive(cand_alive)
  );

  assign end_pos    = (start_pos == '0) ? last_pos : start_pos - 1'b1;
  assign at_end     = (pos == end_pos);
  assign opens      = (state == S_ARM) && (pos == start_pos);
  assign active     = bit_en && (opens || state == S_SCAN || state == S_LATE);
  assign surv_next  = (cand_alive && surv_cnt != 2'd2) ? surv_cnt + 1'b1 : surv_cnt;
  assign pick_pos   = (surv_cnt == 2'd0) ? pos : surv_pos;
  assign next_start = (align_pos >= last_pos) ? '0 : align_pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_ARM;
      start_pos   <= '0;
      span_cnt    <= '0;
      surv_cnt    <= '0;
      surv_pos    <= '0;
      align_pos   <= '0;
      in_frame    <= 1'b0;
      freeze      <= 1'b1;
      fbit_strobe <= 1'b0;
      lock_strobe <= 1'b0;
    end else begin
      fbit_strobe <= 1'b0;
      lock_strobe <= 1'b0;
      if (reframe_req) begin
        state    <= S_ARM;
        span_cnt <= '0;
        surv_cnt <= '0;
        in_frame <= 1'b0;
        freeze   <= 1'b1;
        if (state == S_LOCK) start_pos <= next_start;
      end else begin
        case (state)
          S_LOCK: begin
            fbit_strobe <= bit_en && (pos == align_pos);
          end
          S_LATE: begin
            if (active) begin
              if (cand_alive) begin
                state       <= S_LOCK;
                align_pos   <= pos;
                in_frame    <= 1'b1;
                freeze      <= 1'b0;
                lock_strobe <= 1'b1;
              end else if (at_end) begin
                state    <= S_ARM;
                span_cnt <= '0;
                surv_cnt <= '0;
              end
            end
          end
          default: begin
            if (active) begin
              if (at_end) begin
                surv_cnt <= '0;
                if (span_cnt < DECIDE_AT) begin
                  state    <= S_SCAN;
                  span_cnt <= span_cnt + 1'b1;
                end else if (surv_next == 2'd0) begin
                  state    <= S_ARM;
                  span_cnt <= '0;
                end else if (surv_next == 2'd1) begin
                  state       <= S_LOCK;
                  align_pos   <= pick_pos;
                  in_frame    <= 1'b1;
                  freeze      <= 1'b0;
                  lock_strobe <= 1'b1;
                end else if (span_cnt == LATE_AT) begin
                  state    <= S_LATE;
                  span_cnt <= LATE_SPAN;
                end else begin
                  span_cnt <= span_cnt + 1'b1;
                end
              end else begin
                state    <= S_SCAN;
                surv_cnt <= surv_next;
                if (cand_alive && surv_cnt == 2'd0) surv_pos <= pos;
              end
            end
          end
        endcase
      end
    end
  end

  p_fbit_needs_lock_r10: assert property (@(posedge clk) disable iff (rst)
    fbit_strobe |-> in_frame);

  p_lock_pulse_edge_r10: assert property (@(posedge clk) disable iff (rst)
    lock_strobe |-> (in_frame && !$past(in_frame)));

  p_reframe_drops_r8: assert property (@(posedge clk) disable iff (rst)
    reframe_req |=> !in_frame);

  p_align_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (in_frame && $past(in_frame)) |-> $stable(align_pos));

  p_freeze_in_search_r9: assert property (@(posedge clk) disable iff (rst)
    !in_frame |-> freeze);

  p_span_bound_r7: assert property (@(posedge clk) disable iff (rst)
    span_cnt <= LATE_SPAN);

endmodule

// File: tb/t1fa_aligner_bench.sv
`timescale 1ns/1ps
module t1fa_aligner_bench;

  localparam int POS_W = 10;
  localparam int D4_N  = 386;
  localparam int ESF_N = 772;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, bit_en = 1'b0, rx_bit = 1'b0, esf_mode = 1'b0, reframe_req = 1'b0;
  logic in_frame, freeze, fbit_strobe, lock_strobe;
  logic [POS_W-1:0] align_pos;

  t1fa_aligner u_t1fa_aligner (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .esf_mode(esf_mode), .reframe_req(reframe_req), .in_frame(in_frame),
    .align_pos(align_pos), .freeze(freeze), .fbit_strobe(fbit_strobe),
    .lock_strobe(lock_strobe)
  );

  typedef struct {
    int    at;
    bit    inf;
    int    apos;
    int    fbits;
    int    locks;
    string tag;
  } exp_t;

  exp_t q[$];
  int done = 0, fb_tot = 0, lk_tot = 0, n_cmp = 0, n_bad = 0, dsent = 0;
  int span_n = D4_N;
  int cpos[2];
  int ckind[2];   // 0: alternating D4 pattern, 1: ESF 001011 pattern
  bit cen[2];

  function automatic bit esf_seq(int i);
    case (i % 6)
      2, 4, 5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit gen_bit(int idx);
    int p, k;
    bit v;
    p = idx % span_n;
    k = idx / span_n;
    v = 1'b0;
    for (int c = 0; c < 2; c++)
      if (cen[c] && cpos[c] == p)
        v = (ckind[c] == 0) ? ~k[0] : esf_seq(k);
    return v;
  endfunction

  task automatic expect_at(int at, bit inf, int apos, int fbits, int locks, string tag);
    exp_t e;
    e.at = at; e.inf = inf; e.apos = apos; e.fbits = fbits; e.locks = locks; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset(bit esf, int n);
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0; reframe_req = 1'b0; esf_mode = esf;
    span_n = n;
    repeat (4) @(negedge clk);
    dsent = 0;
    rst = 1'b0;
  endtask

  task automatic run_to(int n);
    while (dsent < n) begin
      @(negedge clk);
      rx_bit = gen_bit(dsent);
      bit_en = 1'b1;
      dsent++;
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  task automatic pulse_reframe();
    @(negedge clk) reframe_req = 1'b1;
    @(negedge clk) reframe_req = 1'b0;
  endtask

  // monitor: samples 1 ns after each rising edge and pops due expectations
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        done = 0; fb_tot = 0; lk_tot = 0;
      end else begin
        if (fbit_strobe) fb_tot++;
        if (lock_strobe) lk_tot++;
        if (bit_en) done++;
        while (q.size() > 0 && q[0].at == done) begin
          exp_t e;
          bit ok;
          e = q.pop_front();
          n_cmp++;
          ok = (in_frame == e.inf) && (freeze == !e.inf) &&
               (!e.inf || int'(align_pos) == e.apos) &&
               (e.fbits < 0 || fb_tot == e.fbits) &&
               (e.locks < 0 || lk_tot == e.locks);
          if (!ok) begin
            n_bad++;
            $display("FAIL %s @strobe %0d: got in_frame=%0b freeze=%0b align=%0d fbits=%0d locks=%0d exp in_frame=%0b align=%0d fbits=%0d locks=%0d",
                     e.tag, done, in_frame, freeze, align_pos, fb_tot, lk_tot,
                     e.inf, e.apos, e.fbits, e.locks);
          end
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // S1: D4, one true candidate at 200 plus an ESF-pattern mimic at 250
    cpos[0] = 200; ckind[0] = 0; cen[0] = 1'b1;
    cpos[1] = 250; ckind[1] = 1; cen[1] = 1'b1;
    do_reset(1'b0, D4_N);
    expect_at(0,    1'b0, 0,   0, 0, "R1 reset state");
    expect_at(3859, 1'b0, 0,  -1, 0, "R5 no lock before 10th span closes");
    expect_at(3860, 1'b1, 200, 0, 1, "R5/R3/R2 lock on 10th span, D4 rule drops ESF mimic");
    expect_at(4500, 1'b1, 200, 2, 1, "R10 one framing pulse per span");
    run_to(4500);

    // S2: D4, two equal mimics at 50 and 100 -> timeout, then reframes
    cpos[0] = 50;  ckind[0] = 0; cen[0] = 1'b1;
    cpos[1] = 100; ckind[1] = 0; cen[1] = 1'b1;
    do_reset(1'b0, D4_N);
    expect_at(3860,  1'b0, 0,  -1, 0, "R7 two survivors keep searching");
    expect_at(9314,  1'b0, 0,  -1, 0, "R7 still searching at 24th span");
    expect_at(9315,  1'b1, 50, -1, 1, "R7 first survivor from start 0");
    run_to(9400);
    pulse_reframe();
    expect_at(9401,  1'b0, 0,  -1, 1, "R8/R9 reframe drops alignment");
    expect_at(19014, 1'b0, 0,  -1, 1, "R8 search from 51 not done");
    expect_at(19015, 1'b1, 100, -1, 2, "R8 start past old alignment");
    run_to(19100);
    pulse_reframe();
    expect_at(19101, 1'b0, 0,  -1, 2, "R8 second reframe drops alignment");
    expect_at(29000, 1'b0, 0,  -1, 2, "R8 wrapped search not done");
    expect_at(29001, 1'b1, 50, -1, 3, "R8 start wraps past end of span");
    run_to(29001);

    // S3: D4, no framing at all, then a candidate appears
    cen[0] = 1'b0; cen[1] = 1'b0;
    do_reset(1'b0, D4_N);
    expect_at(11580, 1'b0, 0, -1, 0, "R6 empty windows keep restarting");
    run_to(11580);
    cpos[0] = 10; ckind[0] = 0; cen[0] = 1'b1;
    expect_at(15439, 1'b0, 0,  -1, 0, "R6 restarted window not done");
    expect_at(15440, 1'b1, 10, -1, 1, "R6 lock at end of restarted window");
    run_to(15440);

    // S4: ESF, true candidate at 300 and a D4-style mimic at 500
    cpos[0] = 300; ckind[0] = 1; cen[0] = 1'b1;
    cpos[1] = 500; ckind[1] = 0; cen[1] = 1'b1;
    do_reset(1'b1, ESF_N);
    expect_at(0,    1'b0, 0,   0, 0, "R1 reset state in ESF");
    expect_at(7719, 1'b0, 0,  -1, 0, "R2 ESF span is 772 bits");
    expect_at(7720, 1'b1, 300, -1, 1, "R4 ESF rule drops alternating mimic");
    run_to(7720);

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R1-all: got %0d unchecked expectations exp 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule